// File: doc/BRIEF.md
# I2C Register-Port Slave

This block is the bus-facing side of a small register file. An I2C master addresses it with a 7-bit device address. The upper six bits of that address are fixed by a parameter, and the lowest bit comes from a strap input. The master first sends a sub-address byte and then reads or writes 8-bit registers through a simple parallel port. The register bank behind that port is outside this block.

The sub-address byte has two fields:
- Its lower seven bits load the register pointer.
- Its top bit selects the pointer mode for the rest of the transfer. When the bit is set, the pointer steps by one after every data byte and wraps from 127 to 0. When the bit is clear, every data byte uses the same register.

A read is a write phase that sets the sub-address, followed by a repeated START with the read bit set. The slave then sends bytes for as long as the master acknowledges them.

SCL and SDA are sampled by a much faster system clock. Both lines pass through a synchroniser, and the slave finds edges, START and STOP in that clock domain. The slave pulls SDA low through an open-drain output enable and never drives SCL.

Top module: `i2c_regport_slave`

## Requirements
- R1: While reset is held, and after it is released, `sda_oe`, `reg_wr_en` and `reg_rd_en` are all 0.
- R2: The slave acknowledges an address byte whose upper seven bits are 0b001100 followed by the value of `sa0_strap`. It acknowledges by pulling SDA low during the ninth clock.
- R3: When the address does not match, the slave acknowledges nothing and writes no register for the rest of that transaction. `sda_oe` stays 0 until the next START.
- R4: The slave acknowledges the byte after a write address as the sub-address. Bits 6:0 of that byte become the register pointer.
- R5: The slave acknowledges every data byte of a write. Each such byte produces exactly one single-cycle `reg_wr_en` pulse, with `reg_addr` equal to the pointer and `reg_wr_data` equal to the byte.
- R6: When sub-address bit 7 is 1, the pointer advances by one after each data byte, written or read, and wraps from 127 to 0.
- R7: When sub-address bit 7 is 0, every data byte of the transfer uses the same register.
- R8: After a repeated START with the read bit set, the slave sends the register at the pointer, most significant bit first. It continues with further bytes while the master acknowledges. After a NACK it releases SDA until the next START or STOP.
- R9: A STOP or START in the middle of a byte abandons that byte. No register is written, SDA is released, and the next transaction works normally.
- R10: `sda_oe` changes only while SCL is low.
- R11: Transfers work at both 100 kHz and 400 kHz SCL with a 250 MHz system clock. More generally they work with any SCL phase of at least 16 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sa0_strap | input | 1 | Low bit of the device address |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr | output | 7 | Register pointer presented to the bank |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_en | output | 1 | One-cycle pulse: the byte at `reg_addr` has been taken |
| reg_rd_data | input | 8 | Bank contents at `reg_addr`, combinational |

## Verification
The bench builds the block with its default parameters: upper address bits 0b001100 and a two-stage synchroniser. It toggles `sa0_strap` so that both device addresses, 0x18 and 0x19, are exercised, and it covers the mismatch case by addressing the one that is not selected.

Most traffic uses a compressed bit period of 40 system clocks. This keeps the wrap from 127 to 0, burst and fixed-pointer transfers, NACK termination and mid-byte aborts affordable in run time. One read at 400 kHz timing and one write at 100 kHz timing confirm that the same logic works at real bus rates.

// File: rtl/i2c_rp_pkg.sv
// Shared definitions for the I2C register-port slave.
// Assumes an 8-bit data byte whose top sub-address bit is the pointer mode.
package i2c_rp_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } fsm_t;

endpackage

// File: rtl/i2c_rp_sync.sv
// Multi-stage synchroniser for the SCL and SDA pins.
// Assumes both lines idle high; the reset value is 1 so no false edge appears.
module i2c_rp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // capture the asynchronous pins
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff[0] <= 1'b1;
                    sda_ff[0] <= 1'b1;
                end else begin
                    scl_ff[0] <= scl_raw;
                    sda_ff[0] <= sda_raw;
                end
            end
        end else begin : g_next
            // move each sample one flop further down the chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff[i] <= 1'b1;
                    sda_ff[i] <= 1'b1;
                end else begin
                    scl_ff[i] <= scl_ff[i-1];
                    sda_ff[i] <= sda_ff[i-1];
                end
            end
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

endmodule

// File: rtl/i2c_rp_cond.sv
// Bus condition detector: SCL edges, START (SDA falls while SCL is high)
// and STOP (SDA rises while SCL is high).
// Assumes synchronised inputs with equal delay on both lines.
module i2c_rp_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_d;
    logic sda_d;

    // hold the previous sample of each line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_rp_ptr.sv
// Register pointer: loaded from the sub-address and stepped per data byte
// when the increment mode is selected. Wraps modulo 2**PTR_W.
module i2c_rp_ptr
    import i2c_rp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             load_inc,
    input  logic             step,
    output logic [PTR_W-1:0] ptr,
    output logic             inc_mode
);

    // load on sub-address, advance on each byte in increment mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            inc_mode <= 1'b0;
        end else if (load) begin
            ptr      <= load_val;
            inc_mode <= load_inc;
        end else if (step && inc_mode) begin
            ptr <= ptr + 1'b1;
        end
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !inc_mode) |=> $stable(ptr)); // R7

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && inc_mode) |=> (ptr == $past(ptr) + 1'b1)); // R6

endmodule

// File: rtl/i2c_rp_ctrl.sv
// Transaction sequencer: address match, sub-address capture, write and read
// byte streaming, ACK generation and NACK handling.
// Assumes one-cycle edge/condition pulses and a combinational read port.
module i2c_rp_ctrl
    import i2c_rp_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR_HI = 6'b001100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sa0,
    input  logic              scl_level,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              ptr_load,
    output logic [PTR_W-1:0]  ptr_load_val,
    output logic              ptr_load_inc,
    output logic              ptr_step,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_en
);

    fsm_t              state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic              rw;
    logic              mack;

    // bus-driven state machine; START and STOP override every state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            bit_cnt      <= '0;
            shreg        <= '0;
            txreg        <= '0;
            rw           <= 1'b0;
            mack         <= 1'b0;
            sda_oe       <= 1'b0;
            ptr_load     <= 1'b0;
            ptr_load_val <= '0;
            ptr_load_inc <= 1'b0;
            ptr_step     <= 1'b0;
            wr_en        <= 1'b0;
            wr_data      <= '0;
            rd_en        <= 1'b0;
        end else begin
            ptr_load <= 1'b0;
            ptr_step <= 1'b0;
            wr_en    <= 1'b0;
            rd_en    <= 1'b0;
            if (start_det) begin
                state   <= ST_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_SUB, ST_WR: begin
                        if (scl_rise && bit_cnt < CNT_W'(BYTE_W)) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
                            bit_cnt <= '0;
                            if (state == ST_DEV) begin
                                if (shreg[BYTE_W-1:1] == {DEV_ADDR_HI, sa0}) begin
                                    sda_oe <= 1'b1;
                                    rw     <= shreg[0];
                                    state  <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else if (state == ST_SUB) begin
                                sda_oe       <= 1'b1;
                                ptr_load     <= 1'b1;
                                ptr_load_val <= shreg[PTR_W-1:0];
                                ptr_load_inc <= shreg[BYTE_W-1];
                                state        <= ST_SUB_ACK;
                            end else begin
                                sda_oe   <= 1'b1;
                                wr_en    <= 1'b1;
                                wr_data  <= shreg;
                                ptr_step <= 1'b1;
                                state    <= ST_WR_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK, ST_SUB_ACK, ST_WR_ACK: begin
                        if (scl_fall) begin
                            if (state == ST_DEV_ACK && rw) begin
                                txreg    <= rd_data;
                                sda_oe   <= ~rd_data[BYTE_W-1];
                                rd_en    <= 1'b1;
                                ptr_step <= 1'b1;
                                bit_cnt  <= CNT_W'(1);
                                state    <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= (state == ST_DEV_ACK) ? ST_SUB : ST_WR;
                            end
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (bit_cnt < CNT_W'(BYTE_W)) begin
                                sda_oe  <= ~txreg[BYTE_W-2];
                                txreg   <= {txreg[BYTE_W-2:0], 1'b0};
                                bit_cnt <= bit_cnt + 1'b1;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                txreg    <= rd_data;
                                sda_oe   <= ~rd_data[BYTE_W-1];
                                rd_en    <= 1'b1;
                                ptr_step <= 1'b1;
                                bit_cnt  <= CNT_W'(1);
                                state    <= ST_RD;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_level); // R10

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!sda_oe && !wr_en)); // R3

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe); // R9

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R5

endmodule

// File: rtl/i2c_regport_slave.sv
// Top of the I2C register-port slave: synchroniser, condition detector,
// sequencer and pointer. Never drives SCL.
// Assumes the attached bank returns reg_rd_data combinationally.
module i2c_regport_slave
    import i2c_rp_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR_HI = 6'b001100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sa0_strap,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wr_data,
    output logic              reg_rd_en,
    input  logic [BYTE_W-1:0] reg_rd_data
);

    logic             scl_s, sda_s;
    logic             scl_rise, scl_fall, start_det, stop_det;
    logic             ptr_load, ptr_load_inc, ptr_step, inc_mode;
    logic [PTR_W-1:0] ptr_load_val;

    i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_raw (scl_i),
        .sda_raw (sda_i),
        .scl_s   (scl_s),
        .sda_s   (sda_s)
    );

    i2c_rp_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rp_ctrl #(.DEV_ADDR_HI(DEV_ADDR_HI)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sa0          (sa0_strap),
        .scl_level    (scl_s),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .rd_data      (reg_rd_data),
        .sda_oe       (sda_oe),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .ptr_load_inc (ptr_load_inc),
        .ptr_step     (ptr_step),
        .wr_en        (reg_wr_en),
        .wr_data      (reg_wr_data),
        .rd_en        (reg_rd_en)
    );

    i2c_rp_ptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .load_inc (ptr_load_inc),
        .step     (ptr_step),
        .ptr      (reg_addr),
        .inc_mode (inc_mode)
    );

    AST_NO_STROBE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en)); // R5

endmodule

// File: tb/i2c_regport_slave_tb.sv
module i2c_regport_slave_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sa0_strap = 1'b0;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic       sda_oe;
    logic [6:0] reg_addr;
    logic       reg_wr_en;
    logic [7:0] reg_wr_data;
    logic       reg_rd_en;
    logic [7:0] reg_rd_data;
    logic       sda_line;

    logic [7:0] bank [128];
    int wr_count = 0;
    int oe_seen = 0;
    int edge_viol = 0;
    logic oe_prev = 1'b0;
    int checks = 0;
    int errors = 0;
    int q = 10;
    logic done = 1'b0;

    always #2 clk = ~clk;

    assign sda_line    = sda_drv & ~sda_oe;
    assign reg_rd_data = bank[reg_addr];

    i2c_regport_slave u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sa0_strap   (sa0_strap),
        .scl_i       (scl_drv),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_en   (reg_rd_en),
        .reg_rd_data (reg_rd_data)
    );

    // bank model: seeded during reset, written by the strobe
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) bank[i] <= 8'(i) ^ 8'h5A;
        end else if (reg_wr_en) begin
            bank[reg_addr] <= reg_wr_data;
            wr_count <= wr_count + 1;
        end
    end

    // watch SDA drive: count activity and changes while SCL is high
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_drv) edge_viol <= edge_viol + 1;
        if (sda_oe) oe_seen <= oe_seen + 1;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        repeat (q) @(negedge clk);
    endtask

    task automatic bstart();
        sda_drv = 1'b1; tick();
        scl_drv = 1'b1; tick();
        sda_drv = 1'b0; tick();
        scl_drv = 1'b0; tick();
    endtask

    task automatic bstop();
        sda_drv = 1'b0; tick();
        scl_drv = 1'b1; tick();
        sda_drv = 1'b1; tick();
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_drv = b;    tick();
        scl_drv = 1'b1; tick();
        s = sda_line;   tick();
        scl_drv = 1'b0; tick();
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            d = {d[6:0], s};
        end
        clk_bit(!give_ack, s);
    endtask

    task automatic wr_txn(input logic [6:0] dev, input logic [7:0] sub,
                          input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input int n, output int nacks);
        logic a;
        nacks = 0;
        bstart();
        wbyte({dev, 1'b0}, a); if (!a) nacks++;
        wbyte(sub, a);         if (!a) nacks++;
        if (n > 0) begin wbyte(d0, a); if (!a) nacks++; end
        if (n > 1) begin wbyte(d1, a); if (!a) nacks++; end
        if (n > 2) begin wbyte(d2, a); if (!a) nacks++; end
        bstop();
    endtask

    task automatic rd_txn(input logic [6:0] dev, input logic [7:0] sub, input int n,
                          output logic [7:0] r0, output logic [7:0] r1,
                          output logic [7:0] r2, output int nacks, output logic rel);
        logic a;
        logic s;
        nacks = 0;
        r0 = '0; r1 = '0; r2 = '0;
        bstart();
        wbyte({dev, 1'b0}, a); if (!a) nacks++;
        wbyte(sub, a);         if (!a) nacks++;
        bstart();
        wbyte({dev, 1'b1}, a); if (!a) nacks++;
        rbyte(n > 1, r0);
        if (n > 1) rbyte(n > 2, r1);
        if (n > 2) rbyte(1'b0, r2);
        clk_bit(1'b1, s);
        rel = s;
        bstop();
    endtask

    localparam logic [14:0] VEC [8] = '{
        {7'h01, 8'h3C}, {7'h02, 8'hFF}, {7'h7F, 8'h00}, {7'h40, 8'hA5},
        {7'h00, 8'h81}, {7'h33, 8'h7E}, {7'h55, 8'h01}, {7'h2A, 8'h80}
    };

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int nk;
        int wc;
        int os;
        logic [7:0] r0, r1, r2, keep;
        logic rel;
        logic a;
        logic s;

        // R1: reset state
        repeat (8) @(negedge clk);
        chk("R1 sda_oe in reset", sda_oe, 0);
        chk("R1 wr_en in reset", reg_wr_en, 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R1 rd_en after reset", reg_rd_en, 0);
        chk("R1 sda_oe after reset", sda_oe, 0);

        // table walk: single-byte write then read back (R2 R4 R5 R8)
        for (int v = 0; v < 8; v++) begin
            wr_txn(7'h18, {1'b0, VEC[v][14:8]}, VEC[v][7:0], 8'h00, 8'h00, 1, nk);
            chk("R2 R4 R5 write acks", nk, 0);
            chk("R5 bank after write", bank[VEC[v][14:8]], VEC[v][7:0]);
            rd_txn(7'h18, {1'b0, VEC[v][14:8]}, 1, r0, r1, r2, nk, rel);
            chk("R8 read acks", nk, 0);
            chk("R8 read data", r0, VEC[v][7:0]);
        end

        // R2: strap high moves the address to 0x19; R3: 0x18 is then foreign
        sa0_strap = 1'b1;
        wr_txn(7'h19, 8'h05, 8'hC3, 8'h00, 8'h00, 1, nk);
        chk("R2 strap-high acks", nk, 0);
        chk("R2 strap-high write", bank[5], 8'hC3);
        wc = wr_count;
        os = oe_seen;
        keep = bank[6];
        wr_txn(7'h18, 8'h06, 8'h11, 8'h00, 8'h00, 1, nk);
        chk("R3 mismatch nacks", nk, 3);
        chk("R3 mismatch no write", wr_count, wc);
        chk("R3 mismatch no drive", oe_seen, os);
        chk("R3 mismatch register kept", bank[6], keep);
        sa0_strap = 1'b0;

        // R6: increment with wrap 127 -> 0, R5 one strobe per byte
        wc = wr_count;
        wr_txn(7'h18, 8'hFE, 8'hA1, 8'hA2, 8'hA3, 3, nk);
        chk("R5 burst acks", nk, 0);
        chk("R5 burst strobes", wr_count - wc, 3);
        chk("R6 reg 7E", bank[8'h7E], 8'hA1);
        chk("R6 reg 7F", bank[8'h7F], 8'hA2);
        chk("R6 wrap to reg 00", bank[0], 8'hA3);
        rd_txn(7'h18, 8'hFE, 3, r0, r1, r2, nk, rel);
        chk("R8 burst read acks", nk, 0);
        chk("R6 R8 burst byte0", r0, 8'hA1);
        chk("R6 R8 burst byte1", r1, 8'hA2);
        chk("R6 R8 burst byte2", r2, 8'hA3);
        chk("R8 released after nack", rel, 1);

        // R7: fixed pointer
        keep = bank[8'h11];
        wr_txn(7'h18, 8'h10, 8'h31, 8'h32, 8'h33, 3, nk);
        chk("R7 fixed acks", nk, 0);
        chk("R7 fixed last wins", bank[8'h10], 8'h33);
        chk("R7 neighbour untouched", bank[8'h11], keep);
        rd_txn(7'h18, 8'h10, 2, r0, r1, r2, nk, rel);
        chk("R7 fixed read 0", r0, 8'h33);
        chk("R7 fixed read 1", r1, 8'h33);

        // R9: STOP in the middle of a data byte
        keep = bank[8'h20];
        wc = wr_count;
        bstart();
        wbyte(8'h30, a);
        wbyte(8'hA0, a);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
        bstop();
        repeat (4) @(negedge clk);
        chk("R9 abort no write", wr_count, wc);
        chk("R9 abort register kept", bank[8'h20], keep);
        chk("R9 abort released", sda_oe, 0);
        rd_txn(7'h18, 8'h20, 1, r0, r1, r2, nk, rel);
        chk("R9 recovery acks", nk, 0);
        chk("R9 recovery data", r0, keep);

        // R11: real bus timing
        q = 156;
        rd_txn(7'h18, 8'h05, 1, r0, r1, r2, nk, rel);
        chk("R11 400k read acks", nk, 0);
        chk("R11 400k read data", r0, 8'hC3);
        q = 625;
        wr_txn(7'h18, 8'h07, 8'h5D, 8'h00, 8'h00, 1, nk);
        chk("R11 100k write acks", nk, 0);
        q = 10;
        rd_txn(7'h18, 8'h07, 1, r0, r1, r2, nk, rel);
        chk("R11 100k write landed", r0, 8'h5D);

        // R10: drive changes only with SCL low
        chk("R10 sda_oe edges while SCL high", edge_viol, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule